// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general-purpose register store of a processor core that keeps separate register copies for its exception modes. An instruction names one of 16 architectural registers with a 4-bit index. The block turns that index, together with the processor mode, into one of 31 physical entries. The banked copies are ordinary storage entries that always exist. A mode change only changes which entry an index resolves to, so a handler entered on an exception finds its own stack pointer and link register. No software has to save them first.

The block has two combinational read ports and one write port. All three ports resolve their indices through a single bank selection. That selection normally follows the current mode. Two qualifiers change it without changing the mode itself. The user-bank qualifier forces the user copies, as a store or load of several registers with the user flag needs. The cross-mode qualifier makes the ports resolve as if a named mode were active, so context-switch code can reach another mode's stack pointer or link register. Program-counter behaviour, status registers and instruction decode live outside the block.

Top module: `mode_bank_rf`

## Requirements
- R1: Indices 0 to 7 reach one shared entry each, whatever the mode or qualifier. A value written in any mode is read back in every mode.
- R2: Indices 8 to 12 have a private copy in fast-interrupt mode (code 0x11). Every other mode uses the shared user copy of these indices.
- R3: Indices 13 and 14 have a private copy in each of fast-interrupt (0x11), interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) mode. System mode (0x1F) and user mode (0x10) share one copy.
- R4: Index 15 reaches one shared entry in every mode.
- R5: The 5-bit mode input uses these codes: user 0x10, fast-interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B, system 0x1F. Any other code selects the user copies.
- R6: While `usr_bank_i` is 1, all three ports resolve as in user mode. This overrides both `cur_mode_i` and the cross-mode qualifier.
- R7: While `xm_en_i` is 1 and `usr_bank_i` is 0, all three ports resolve with `xm_mode_i` in place of `cur_mode_i`. The current mode is then ignored.
- R8: When `we_i` is 1, `wr_data_i` is stored at the rising clock edge into the entry that `wr_idx_i` resolves to. When `we_i` is 0, no entry changes.
- R9: A read of the entry being written in the same cycle returns the old value. The new value is seen from the cycle after the edge.
- R10: The two read ports resolve and return their entries independently in the same cycle.
- R11: `clr_i` (a synchronous clear, used only by the bench) zeroes all 31 entries at the edge and takes priority over a write. The reset input leaves register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; does not touch contents |
| clr_i | input | 1 | Synchronous clear of all entries |
| cur_mode_i | input | 5 | Current processor mode code |
| usr_bank_i | input | 1 | Force user-bank resolution on all ports |
| xm_en_i | input | 1 | Resolve ports with `xm_mode_i` instead of the current mode |
| xm_mode_i | input | 5 | Mode code used for cross-mode access |
| ra_idx_i | input | 4 | Read port A register index |
| ra_data_o | output | DW | Read port A data |
| rb_idx_i | input | 4 | Read port B register index |
| rb_data_o | output | DW | Read port B data |
| we_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write register index |
| wr_data_i | input | DW | Write data |

## Verification
A write and a read can fall in the same cycle. When they target the same physical entry, the read must return the pre-edge value. Directed cases provoke this by writing an index while both read ports name it. The bench checks that the old value appears before the edge and the new value in the next cycle. The random phase repeats the collision on a large scale by drawing write and read indices from 16 values under changing modes and qualifiers. Each cycle, both read ports are compared before the edge with a bench model that only commits writes after the edge.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  localparam int IDXW   = 4;
  localparam int MODEW  = 5;
  localparam int NARCH  = 1 << IDXW;
  localparam int NFIQB  = 7;                       // indices 8..14
  localparam int NXCPT  = 4;                       // irq, svc, abt, und
  localparam int NPAIR  = 2;                       // indices 13..14
  localparam int NPHYS  = NARCH + NFIQB + NXCPT * NPAIR;
  localparam int PW     = $clog2(NPHYS);
  localparam int FIQ_LO = 8;
  localparam int FIQ_HI = 14;
  localparam int PR_LO  = 13;
  localparam int FIQ_BASE  = NARCH;
  localparam int PAIR_BASE = NARCH + NFIQB;

  localparam logic [MODEW-1:0] MD_USR = 5'h10;
  localparam logic [MODEW-1:0] MD_FIQ = 5'h11;
  localparam logic [MODEW-1:0] MD_IRQ = 5'h12;
  localparam logic [MODEW-1:0] MD_SVC = 5'h13;
  localparam logic [MODEW-1:0] MD_ABT = 5'h17;
  localparam logic [MODEW-1:0] MD_UND = 5'h1B;
  localparam logic [MODEW-1:0] MD_SYS = 5'h1F;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

endpackage

// File: rtl/mbrf_mode_dec.sv
module mbrf_mode_dec
  import mbrf_pkg::*;
(
  input  logic [MODEW-1:0] cur_mode_i,
  input  logic             usr_bank_i,
  input  logic             xm_en_i,
  input  logic [MODEW-1:0] xm_mode_i,
  output bank_e            bank_o
);

  logic [MODEW-1:0] eff_mode;

  // qualifier priority: forced user bank, then cross-mode, then current mode
  always_comb begin
    eff_mode = xm_en_i ? xm_mode_i : cur_mode_i;
    if (usr_bank_i) begin
      bank_o = BK_USR;
    end else begin
      unique case (eff_mode)
        MD_FIQ:  bank_o = BK_FIQ;
        MD_IRQ:  bank_o = BK_IRQ;
        MD_SVC:  bank_o = BK_SVC;
        MD_ABT:  bank_o = BK_ABT;
        MD_UND:  bank_o = BK_UND;
        default: bank_o = BK_USR;   // user, system and unlisted codes
      endcase
    end
  end

endmodule

// File: rtl/mbrf_addr_map.sv
module mbrf_addr_map
  import mbrf_pkg::*;
(
  input  logic [IDXW-1:0] idx_i,
  input  bank_e           bank_i,
  output logic [PW-1:0]   phys_o
);

  logic          in_fiq_rng;
  logic          in_pair_rng;
  logic [PW-1:0] fiq_off;
  logic [PW-1:0] pair_sel;
  logic [PW-1:0] pair_base;

  always_comb begin
    in_fiq_rng  = (idx_i >= IDXW'(FIQ_LO)) && (idx_i <= IDXW'(FIQ_HI));
    in_pair_rng = (idx_i >= IDXW'(PR_LO))  && (idx_i <= IDXW'(FIQ_HI));
    fiq_off     = PW'(idx_i) - PW'(FIQ_LO);
    pair_sel    = PW'(idx_i) - PW'(PR_LO);
    pair_base   = PW'(PAIR_BASE)
                + PW'(NPAIR) * (PW'(bank_i) - PW'(BK_IRQ));
    phys_o      = PW'(idx_i);
    if (bank_i == BK_FIQ) begin
      if (in_fiq_rng) phys_o = PW'(FIQ_BASE) + fiq_off;
    end else if (bank_i != BK_USR) begin
      if (in_pair_rng) phys_o = pair_base + pair_sel;
    end
  end

endmodule

// File: rtl/mbrf_storage.sv
module mbrf_storage
  import mbrf_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NRD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [PW-1:0] wsel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [PW-1:0] rsel_i  [NRD],
  output logic [DW-1:0] rdata_o [NRD]
);

  logic [DW-1:0]    mem_q [NPHYS];
  logic [DW-1:0]    mem_d [NPHYS];
  logic [NPHYS-1:0] ld_en;

  for (genvar e = 0; e < NPHYS; e++) begin : g_ent
    // next-state: clear wins over write
    always_comb begin
      ld_en[e] = clr_i | (we_i & (wsel_i == PW'(e)));
      mem_d[e] = clr_i ? '0 : wdata_i;
    end
    // register: clock enable only, contents not reset
    always_ff @(posedge clk) begin
      if (ld_en[e]) mem_q[e] <= mem_d[e];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = mem_q[rsel_i[p]];
  end

  AST_WRITE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !clr_i) |=> (mem_q[$past(wsel_i)] == $past(wdata_i))); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (mem_q[0] == '0 && mem_q[NPHYS-1] == '0)); // R11

endmodule

// File: rtl/mode_bank_rf.sv
module mode_bank_rf
  import mbrf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [MODEW-1:0] cur_mode_i,
  input  logic             usr_bank_i,
  input  logic             xm_en_i,
  input  logic [MODEW-1:0] xm_mode_i,
  input  logic [IDXW-1:0]  ra_idx_i,
  output logic [DW-1:0]    ra_data_o,
  input  logic [IDXW-1:0]  rb_idx_i,
  output logic [DW-1:0]    rb_data_o,
  input  logic             we_i,
  input  logic [IDXW-1:0]  wr_idx_i,
  input  logic [DW-1:0]    wr_data_i
);

  localparam int NRD   = 2;
  localparam int NPORT = NRD + 1;      // read ports first, write port last

  bank_e          bank;
  logic [IDXW-1:0] port_idx  [NPORT];
  logic [PW-1:0]   port_phys [NPORT];
  logic [PW-1:0]   rd_phys   [NRD];
  logic [DW-1:0]   rd_data   [NRD];

  mbrf_mode_dec u_dec (
    .cur_mode_i (cur_mode_i),
    .usr_bank_i (usr_bank_i),
    .xm_en_i    (xm_en_i),
    .xm_mode_i  (xm_mode_i),
    .bank_o     (bank)
  );

  assign port_idx[0]       = ra_idx_i;
  assign port_idx[1]       = rb_idx_i;
  assign port_idx[NPORT-1] = wr_idx_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    mbrf_addr_map u_map (
      .idx_i  (port_idx[p]),
      .bank_i (bank),
      .phys_o (port_phys[p])
    );
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rsel
    assign rd_phys[p] = port_phys[p];
  end

  mbrf_storage #(.DW(DW), .NRD(NRD)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .we_i    (we_i),
    .wsel_i  (port_phys[NPORT-1]),
    .wdata_i (wr_data_i),
    .rsel_i  (rd_phys),
    .rdata_o (rd_data)
  );

  assign ra_data_o = rd_data[0];
  assign rb_data_o = rd_data[1];

  AST_LOW_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx_i < IDXW'(8)) |-> (port_phys[0] == PW'(ra_idx_i))); // R1

  AST_PC_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx_i == IDXW'(15)) |-> (port_phys[NPORT-1] == PW'(15))); // R4

  AST_SYS_AS_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (!usr_bank_i && !xm_en_i && cur_mode_i == MD_SYS) |-> (bank == BK_USR)); // R3

  AST_FORCE_USER: assert property (@(posedge clk) disable iff (!rst_n)
    usr_bank_i |-> (port_phys[1] == PW'(rb_idx_i))); // R6

  AST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !clr_i && port_phys[NPORT-1] == port_phys[0])
      |=> (port_phys[0] != $past(port_phys[0]) || ra_data_o == $past(wr_data_i))); // R9

endmodule

// File: tb/sim_mode_bank_rf.sv
module sim_mode_bank_rf;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr;
  logic [4:0]    cur_mode;
  logic          usr;
  logic          xm_en;
  logic [4:0]    xm_mode;
  logic [3:0]    ra_idx, rb_idx, wr_idx;
  logic [DW-1:0] ra_data, rb_data, wr_data;
  logic          we;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [DW-1:0] mdl [31];

  always #2 clk = ~clk;

  mode_bank_rf #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .cur_mode_i(cur_mode),
    .usr_bank_i(usr), .xm_en_i(xm_en), .xm_mode_i(xm_mode),
    .ra_idx_i(ra_idx), .ra_data_o(ra_data), .rb_idx_i(rb_idx),
    .rb_data_o(rb_data), .we_i(we), .wr_idx_i(wr_idx), .wr_data_i(wr_data)
  );

  // bench model of the index/mode to entry mapping
  function automatic int bank_of(logic [4:0] m, bit u, bit x, logic [4:0] xmm);
    logic [4:0] e;
    if (u) return 0;
    e = x ? xmm : m;
    case (e)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int slot(int idx, int b);
    if (b == 1 && idx >= 8 && idx <= 14) return 16 + idx - 8;
    if (b >= 2 && idx >= 13 && idx <= 14) return 23 + 2 * (b - 2) + (idx - 13);
    return idx;
  endfunction

  function automatic int cur_slot(int idx);
    return slot(idx, bank_of(cur_mode, usr, xm_en, xm_mode));
  endfunction

  function automatic string grp(int idx);
    if (idx < 8)  return "R1";
    if (idx < 13) return "R2";
    if (idx < 15) return "R3";
    return "R4";
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic ctx(logic [4:0] m, bit u, bit x, logic [4:0] xmm);
    cur_mode = m; usr = u; xm_en = x; xm_mode = xmm;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(int idx, logic [DW-1:0] d);
    we = 1'b1; wr_idx = 4'(idx); wr_data = d;
    @(posedge clk);
    mdl[cur_slot(idx)] = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(string tag, int a);
    ra_idx = 4'(a); rb_idx = 4'((a + 5) % 16);
    #1;
    chk(tag, $sformatf("portA idx=%0d mode=%h", a, cur_mode), ra_data, mdl[cur_slot(a)]);
    chk("R10", $sformatf("portB idx=%0d", (a + 5) % 16), rb_data, mdl[cur_slot((a + 5) % 16)]);
  endtask

  logic [4:0] modes [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h05};

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1;
        fails++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7411));
    rst_n = 1'b0; clr = 1'b0; we = 1'b0; wr_idx = '0; wr_data = '0;
    ra_idx = '0; rb_idx = '0;
    ctx(5'h10, 0, 0, 5'h10);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // clear, then reset state: all zero (R11)
    clr = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 31; i++) mdl[i] = '0;
    @(negedge clk);
    clr = 1'b0;
    for (int m = 0; m < 8; m++) begin
      ctx(modes[m], 0, 0, 5'h10);
      for (int i = 0; i < 16; i++) rd("R11", i);
    end

    // fill every bank with distinct values
    ctx(5'h10, 0, 0, 5'h10);
    for (int i = 0; i < 16; i++) wr(i, 32'h0100_0000 + 32'(i));
    ctx(5'h11, 0, 0, 5'h10);
    for (int i = 8; i < 15; i++) wr(i, 32'h0200_0000 + 32'(i));
    for (int m = 2; m < 6; m++) begin
      ctx(modes[m], 0, 0, 5'h10);
      wr(13, 32'h0300_0000 + 32'(m * 16 + 13));
      wr(14, 32'h0300_0000 + 32'(m * 16 + 14));
    end
    // every mode, every index (R1..R5)
    for (int m = 0; m < 8; m++) begin
      ctx(modes[m], 0, 0, 5'h10);
      for (int i = 0; i < 16; i++) rd(m == 7 ? "R5" : grp(i), i);
    end
    // explicit values: system shares user r13 (R3), fiq r9 private (R2)
    ctx(5'h1F, 0, 0, 5'h10); ra_idx = 4'd13; #1;
    chk("R3", "sys r13", ra_data, 32'h0100_000D);
    ctx(5'h11, 0, 0, 5'h10); ra_idx = 4'd9; #1;
    chk("R2", "fiq r9", ra_data, 32'h0200_0009);
    ctx(5'h13, 0, 0, 5'h10); ra_idx = 4'd9; #1;
    chk("R2", "svc r9", ra_data, 32'h0100_0009);
    ctx(5'h15, 0, 0, 5'h10); ra_idx = 4'd14; #1;
    chk("R5", "unlisted r14", ra_data, 32'h0100_000E);

    // user-bank qualifier (R6)
    ctx(5'h11, 1, 0, 5'h10); ra_idx = 4'd13; #1;
    chk("R6", "fiq+usr r13", ra_data, 32'h0100_000D);
    ctx(5'h13, 1, 1, 5'h12); ra_idx = 4'd14; #1;
    chk("R6", "usr beats xm r14", ra_data, 32'h0100_000E);
    @(negedge clk);
    ctx(5'h13, 1, 0, 5'h10);
    wr(14, 32'hAAAA_0014);
    ctx(5'h10, 0, 0, 5'h10); ra_idx = 4'd14; #1;
    chk("R6", "usr write lands in user r14", ra_data, 32'hAAAA_0014);
    ctx(5'h13, 0, 0, 5'h10); ra_idx = 4'd14; #1;
    chk("R6", "svc r14 untouched", ra_data, 32'h0300_0000 + 32'(3 * 16 + 14));

    // cross-mode access (R7)
    ctx(5'h10, 0, 1, 5'h12); ra_idx = 4'd13; #1;
    chk("R7", "xm irq r13", ra_data, 32'h0300_0000 + 32'(2 * 16 + 13));
    @(negedge clk);
    ctx(5'h12, 0, 1, 5'h17);
    wr(13, 32'hBBBB_0013);
    ctx(5'h17, 0, 0, 5'h10); ra_idx = 4'd13; #1;
    chk("R7", "abt r13 after xm write", ra_data, 32'hBBBB_0013);
    ctx(5'h12, 0, 0, 5'h10); ra_idx = 4'd13; #1;
    chk("R7", "irq r13 untouched", ra_data, 32'h0300_0000 + 32'(2 * 16 + 13));

    // write enable low changes nothing (R8)
    @(negedge clk);
    ctx(5'h10, 0, 0, 5'h10);
    we = 1'b0; wr_idx = 4'd4; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    ra_idx = 4'd4; #1;
    chk("R8", "we=0 r4", ra_data, 32'h0100_0004);

    // same-cycle write/read collision (R9)
    @(negedge clk);
    ra_idx = 4'd3; rb_idx = 4'd3;
    we = 1'b1; wr_idx = 4'd3; wr_data = 32'h1234_5678; #1;
    chk("R9", "old value A", ra_data, 32'h0100_0003);
    chk("R9", "old value B", rb_data, 32'h0100_0003);
    @(posedge clk);
    mdl[3] = 32'h1234_5678;
    @(negedge clk);
    we = 1'b0; #1;
    chk("R9", "new value next cycle", ra_data, 32'h1234_5678);

    // reset leaves contents (R11)
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) rd("R11", i);

    // clear beats a simultaneous write (R11)
    @(negedge clk);
    clr = 1'b1; we = 1'b1; wr_idx = 4'd6; wr_data = 32'h5555_5555;
    @(posedge clk);
    for (int i = 0; i < 31; i++) mdl[i] = '0;
    @(negedge clk);
    clr = 1'b0; we = 1'b0;
    ctx(5'h11, 0, 0, 5'h10);
    rd("R11", 6); rd("R11", 10);

    // constrained random phase
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      ctx(modes[$urandom % 8], ($urandom % 8) == 0, ($urandom % 4) == 0,
          modes[$urandom % 8]);
      ra_idx  = 4'($urandom);
      rb_idx  = 4'($urandom);
      we      = ($urandom % 2) == 1;
      wr_idx  = 4'($urandom);
      wr_data = $urandom;
      clr     = ($urandom % 300) == 0;
      #1;
      chk(grp(int'(ra_idx)), "random A", ra_data, mdl[cur_slot(int'(ra_idx))]);
      chk("R10", "random B", rb_data, mdl[cur_slot(int'(rb_idx))]);
      @(posedge clk);
      if (clr) begin
        for (int i = 0; i < 31; i++) mdl[i] = '0;
      end else if (we) begin
        mdl[cur_slot(int'(wr_idx))] = wr_data;
      end
    end
    @(negedge clk);
    we = 1'b0; clr = 1'b0;

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule